// File: doc/BRIEF.md
# NAND ECC Syndrome Corrector

This block compares the 3-byte error code read back from a NAND spare area with the 3-byte code recomputed over the same 512-byte sector. It turns the pair into a verdict: clean, a single flipped data bit that can be repaired, a flipped bit inside the stored code itself, or damage beyond repair. For a repairable data error it gives the byte address within the sector and the bit index within that byte. Logic outside the block uses these to toggle the bit in its own sector buffer.

Each code is packed onto a 24-bit port with byte 0 in bits [7:0], byte 1 in bits [15:8] and byte 2 in bits [23:16]. Inside the block each code is rearranged into an ascending parity word, and the two words are XORed into a syndrome. The verdict and the location are captured in one register stage on a valid strobe. They stay unchanged until the next strobe.

Top module: `nand_ecc_syndrome`

## Requirements
- R1: While rst_n is low at a clock edge, res_valid, res_status, err_byte and err_bit all become 0.
- R2: When stored and computed codes are equal, res_status is 0 (clean) and the location outputs are 0.
- R3: Each code is rearranged into the word {byte2[1:0], byte1, byte0, byte2[7:2]} (bit 23 down to bit 0), and the syndrome is the XOR of the two words.
- R4: If every syndrome pair (bits 2k and 2k+1, for k = 0..11) has at least one bit set, res_status is 1 (corrected data).
- R5: For status 1, err_bit is {syn[5], syn[3], syn[1]}, with syn[1] as the LSB.
- R6: For status 1, err_byte is {syn[23], syn[21], ..., syn[9], syn[7]}, with syn[7] as the LSB, so it covers 0 to 511.
- R7: If exactly one syndrome bit is set, res_status is 2 (error in stored code only), and no data location is reported.
- R8: Any other nonzero syndrome gives res_status 3 (uncorrectable).
- R9: err_byte and err_bit are 0 whenever res_status is not 1.
- R10: A result is captured at the clock edge where in_valid is high, and res_valid is high for exactly the following cycle. With in_valid low, the result outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: capture a verdict for the codes on this edge |
| stored_code | input | 24 | Code read from the spare area, byte 0 in the low byte |
| computed_code | input | 24 | Code recomputed over the sector data, same packing |
| res_valid | output | 1 | Pulses for one cycle after a capture |
| res_status | output | 2 | 0 clean, 1 corrected data, 2 code-only error, 3 uncorrectable |
| err_byte | output | 9 | Byte address of the flipped data bit |
| err_bit | output | 3 | Bit index of the flipped data bit |

## Verification
The bench uses the default widths: a 9-bit byte address and a 3-bit bit index, which give twelve syndrome pairs. With these widths every corner of the location space can be reached directly: byte 0 bit 0 (only even bits set), byte 511 bit 7 (only odd bits set), and a single-bit syndrome at each of the 24 positions. Random repairable syndromes also set both bits of some pairs, which checks that decoding reads only the odd bits. Random code pairs, mostly multi-bit, exercise the uncorrectable path.

// File: rtl/nand_ecc_syndrome_pkg.sv
// Package: shared verdict encoding for the syndrome corrector.
// Assumes the two-bit status port carries these values unchanged.
package nand_ecc_syndrome_pkg;
    typedef enum logic [1:0] {
        VERDICT_CLEAN   = 2'd0,
        VERDICT_FIXED   = 2'd1,
        VERDICT_CODEERR = 2'd2,
        VERDICT_FATAL   = 2'd3
    } verdict_t;
endpackage

// File: rtl/ecc_code_arrange.sv
// Rearranges one packed code (byte 0 lowest) into the ascending parity word.
// The word is {byte1, byte0, byte2} rotated right by LOW_SPLIT bits.
// Assumes CODE_W is a multiple of 8 and holds exactly three bytes.
module ecc_code_arrange #(
    parameter int CODE_W    = 24,
    parameter int LOW_SPLIT = 2
) (
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] word_out
);
    localparam int BYTE_W = CODE_W / 3;

    logic [CODE_W-1:0] swapped;

    // Put byte 2 at the bottom, ahead of the rotation.
    always_comb begin
        swapped = {code_in[2*BYTE_W-1:0], code_in[CODE_W-1:2*BYTE_W]};
    end

    // Rotate right so the low bits of byte 2 land at the top.
    always_comb begin
        word_out = {swapped[LOW_SPLIT-1:0], swapped[CODE_W-1:LOW_SPLIT]};
    end
endmodule

// File: rtl/ecc_syndrome_classify.sv
// Sorts a syndrome word into one of four verdicts.
// Assumes the word is made of PAIRS adjacent bit pairs.
module ecc_syndrome_classify
    import nand_ecc_syndrome_pkg::*;
#(
    parameter int PAIRS = 12
) (
    input  logic [2*PAIRS-1:0] syndrome,
    output verdict_t           verdict
);
    localparam int WORD_W = 2 * PAIRS;

    logic [PAIRS-1:0] pair_hit;
    logic             all_pairs;
    logic             one_hot;

    // One flag per pair: at least one of its two bits is set.
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign pair_hit[p] = syndrome[2*p] | syndrome[2*p+1];
    end

    // A single set bit has no other bit below it.
    always_comb begin
        all_pairs = &pair_hit;
        one_hot   = (syndrome != '0) &&
                    ((syndrome & (syndrome - WORD_W'(1))) == '0);
    end

    // The pair rule takes precedence over the single-bit rule.
    always_comb begin
        if (syndrome == '0)
            verdict = VERDICT_CLEAN;
        else if (all_pairs)
            verdict = VERDICT_FIXED;
        else if (one_hot)
            verdict = VERDICT_CODEERR;
        else
            verdict = VERDICT_FATAL;
    end
endmodule

// File: rtl/ecc_error_locate.sv
// Collects the odd syndrome bits into a bit index and a byte address.
// The lowest BIT_IDX_W pairs give the bit index and the rest give the byte address.
module ecc_error_locate #(
    parameter int BYTE_ADDR_W = 9,
    parameter int BIT_IDX_W   = 3
) (
    input  logic [2*(BYTE_ADDR_W+BIT_IDX_W)-1:0] syndrome,
    output logic [BYTE_ADDR_W-1:0]               byte_addr,
    output logic [BIT_IDX_W-1:0]                 bit_idx
);
    // Bit index: odd bits of the lowest pairs.
    for (genvar i = 0; i < BIT_IDX_W; i++) begin : g_bit
        assign bit_idx[i] = syndrome[2*i+1];
    end

    // Byte address: odd bits of the remaining pairs.
    for (genvar j = 0; j < BYTE_ADDR_W; j++) begin : g_byte
        assign byte_addr[j] = syndrome[2*(j+BIT_IDX_W)+1];
    end
endmodule

// File: rtl/nand_ecc_syndrome.sv
// Top: compares the stored and recomputed codes and registers a verdict and
// error location on each in_valid strobe. Assumes 512-byte sectors with 3-byte codes.
module nand_ecc_syndrome
    import nand_ecc_syndrome_pkg::*;
#(
    parameter int BYTE_ADDR_W = 9,
    parameter int BIT_IDX_W   = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [23:0]            stored_code,
    input  logic [23:0]            computed_code,
    output logic                   res_valid,
    output logic [1:0]             res_status,
    output logic [BYTE_ADDR_W-1:0] err_byte,
    output logic [BIT_IDX_W-1:0]   err_bit
);
    localparam int PAIRS  = BYTE_ADDR_W + BIT_IDX_W;
    localparam int WORD_W = 2 * PAIRS;

    logic [WORD_W-1:0]      word_stored;
    logic [WORD_W-1:0]      word_computed;
    logic [WORD_W-1:0]      syndrome;
    verdict_t               verdict;
    logic [BYTE_ADDR_W-1:0] loc_byte;
    logic [BIT_IDX_W-1:0]   loc_bit;

    ecc_code_arrange #(.CODE_W(WORD_W), .LOW_SPLIT(2)) u_arr_stored (
        .code_in (stored_code),
        .word_out(word_stored)
    );

    ecc_code_arrange #(.CODE_W(WORD_W), .LOW_SPLIT(2)) u_arr_computed (
        .code_in (computed_code),
        .word_out(word_computed)
    );

    // Syndrome: bitwise difference of the two ascending words.
    always_comb begin
        syndrome = word_stored ^ word_computed;
    end

    ecc_syndrome_classify #(.PAIRS(PAIRS)) u_classify (
        .syndrome(syndrome),
        .verdict (verdict)
    );

    ecc_error_locate #(.BYTE_ADDR_W(BYTE_ADDR_W), .BIT_IDX_W(BIT_IDX_W)) u_locate (
        .syndrome (syndrome),
        .byte_addr(loc_byte),
        .bit_idx  (loc_bit)
    );

    // Result register: capture on strobe, hold otherwise; location only for data fixes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_status <= 2'd0;
            err_byte   <= '0;
            err_bit    <= '0;
        end else begin
            res_valid <= in_valid;
            if (in_valid) begin
                res_status <= verdict;
                err_byte   <= (verdict == VERDICT_FIXED) ? loc_byte : '0;
                err_bit    <= (verdict == VERDICT_FIXED) ? loc_bit  : '0;
            end
        end
    end

    AST_RESULT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res_status) && $stable(err_byte) && $stable(err_bit)); // R10
    AST_CLEAN_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (stored_code == computed_code) |=> res_status == 2'd0); // R2
    AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ($countones(stored_code ^ computed_code) == 1) |=> res_status == 2'd2); // R7
    AST_TWO_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && ($countones(stored_code ^ computed_code) == 2) |=> res_status == 2'd3); // R8
    AST_LOC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        res_status != 2'd1 |-> (err_byte == '0) && (err_bit == '0)); // R9
endmodule

// File: tb/nand_ecc_syndrome_bench.sv
module nand_ecc_syndrome_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] stored_code = '0;
    logic [23:0] computed_code = '0;
    logic        res_valid;
    logic [1:0]  res_status;
    logic [8:0]  err_byte;
    logic [2:0]  err_bit;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    nand_ecc_syndrome u_nand_ecc_syndrome (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .stored_code(stored_code), .computed_code(computed_code),
        .res_valid(res_valid), .res_status(res_status),
        .err_byte(err_byte), .err_bit(err_bit)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Ascending word per R3, written as an explicit concatenation
    function automatic logic [23:0] asc(input logic [23:0] c);
        return {c[17:16], c[15:8], c[7:0], c[23:18]};
    endfunction

    // Inverse of asc: packs a syndrome word back into code form
    function automatic logic [23:0] pack(input logic [23:0] w);
        return {w[5:0], w[23:22], w[21:14], w[13:6]};
    endfunction

    function automatic void model(input logic [23:0] s, input logic [23:0] c,
                                  output int st, output int by, output int bi);
        logic [23:0] d;
        int ones;
        bit pairs;
        d = asc(s) ^ asc(c);
        ones = 0;
        pairs = 1'b1;
        by = 0;
        bi = 0;
        for (int k = 0; k < 24; k++) ones += d[k];
        for (int k = 0; k < 12; k++) if (!(d[2*k] || d[2*k+1])) pairs = 1'b0;
        if (ones == 0) st = 0;
        else if (pairs) begin
            st = 1;
            for (int k = 0; k < 3; k++) bi += d[2*k+1] << k;
            for (int k = 0; k < 9; k++) by += d[2*k+7] << k;
        end
        else if (ones == 1) st = 2;
        else st = 3;
    endfunction

    // Syndrome word of a repairable error at (byte, bit); extra picks spare even bits
    function automatic logic [23:0] fix_word(input int byt, input int bt, input logic [11:0] extra);
        logic [11:0] loc;
        logic [23:0] w;
        loc = {byt[8:0], bt[2:0]};
        for (int k = 0; k < 12; k++) begin
            w[2*k+1] = loc[k];
            w[2*k]   = loc[k] ? extra[k] : 1'b1;
        end
        return w;
    endfunction

    task automatic apply(input logic [23:0] s, input logic [23:0] c, input string req);
        int st, by, bi;
        @(negedge clk);
        in_valid = 1'b1;
        stored_code = s;
        computed_code = c;
        @(negedge clk);
        in_valid = 1'b0;
        model(s, c, st, by, bi);
        check({req, " valid"}, int'(res_valid), 1);
        check({req, " status"}, int'(res_status), st);
        check({req, " byte"}, int'(err_byte), by);
        check({req, " bit"}, int'(err_bit), bi);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [23:0] c, s;
        int st, by, bi;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check("R1 valid", int'(res_valid), 0);
        check("R1 status", int'(res_status), 0);
        check("R1 loc", int'(err_byte) + int'(err_bit), 0);
        rst_n = 1'b1;

        // R2: identical codes
        apply(24'hA5C3_0F, 24'hA5C3_0F, "R2 equal");
        check("R2 clean", int'(res_status), 0);

        // R7: single differing bit at each position; R9 location stays zero
        for (int k = 0; k < 24; k++) begin
            c = $urandom;
            apply(c ^ (24'd1 << k), c, "R7 single");
            check("R7 code-only", int'(res_status), 2);
            check("R9 quiet", int'(err_byte) + int'(err_bit), 0);
        end

        // R4 R5 R6 corners: byte 0 bit 0 (even bits only), byte 511 bit 7 (odd bits only)
        c = $urandom;
        apply(c ^ pack(24'h555555), c, "R4 even");
        check("R6 byte0", int'(err_byte), 0);
        check("R5 bit0", int'(err_bit), 0);
        apply(c ^ pack(24'hAAAAAA), c, "R4 odd");
        check("R6 byte511", int'(err_byte), 511);
        check("R5 bit7", int'(err_bit), 7);
        // R3: explicit ordering case, byte 300 bit 5
        apply(c ^ pack(fix_word(300, 5, 12'h000)), c, "R3 order");
        check("R3 byte300", int'(err_byte), 300);
        check("R3 bit5", int'(err_bit), 5);

        // R8: two bits at the same pair, then uncorrectable R9
        apply(c ^ pack(24'h3), c, "R8 pair");
        check("R8 fatal", int'(res_status), 3);
        check("R9 fatal quiet", int'(err_byte) + int'(err_bit), 0);

        // R4 R5 R6 random repairable errors with random extra even bits
        for (int n = 0; n < 300; n++) begin
            int by0 = $urandom_range(511, 0);
            int bi0 = $urandom_range(7, 0);
            c = $urandom;
            apply(c ^ pack(fix_word(by0, bi0, 12'($urandom))), c, "R4 rand");
            check("R6 rand byte", int'(err_byte), by0);
            check("R5 rand bit", int'(err_bit), bi0);
        end

        // R8 random code pairs against the model
        for (int n = 0; n < 300; n++) begin
            apply(24'($urandom), 24'($urandom), "R8 rand");
        end

        // R10: hold without strobe, then a one-cycle valid pulse
        c = $urandom;
        apply(c ^ pack(fix_word(77, 2, 12'h0)), c, "R10 load");
        @(negedge clk);
        stored_code = 24'h123456;
        computed_code = 24'h654321;
        check("R10 pulse end", int'(res_valid), 0);
        @(negedge clk);
        check("R10 hold status", int'(res_status), 1);
        check("R10 hold byte", int'(err_byte), 77);
        check("R10 hold bit", int'(err_bit), 2);

        // R1: reset during activity clears results
        apply(c ^ pack(fix_word(9, 1, 12'h0)), c, "R1 pre");
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 again status", int'(res_status), 0);
        check("R1 again loc", int'(err_byte) + int'(err_bit), 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule